// File: doc/BRIEF.md
# Compressed-to-full instruction expander

This block turns one 16-bit compressed instruction into the equivalent 32-bit full-width instruction word. Each narrow format is rewritten into a wide opcode. Register fields are moved to their wide positions and immediates are rescaled. Nothing is executed: there is no register file and no branch handling.

A 32-bit fetch word carries two halfwords. A select input picks which of the two is decoded. A level flag enables the two encodings that only exist on the later architecture level: register branch-with-exchange-and-link and breakpoint. Branch encodings are outside this block. They are reported as undefined, along with every reserved or unused pattern. The expanded word, the undefined flag and a valid pulse appear one clock after a valid input strobe.

Top module: `cinsn_expand`

## Requirements
- R1: When `hi_half_sel` is 1 the instruction is `fetch_word[31:16]`; when it is 0 the instruction is `fetch_word[15:0]`. The other half has no effect.
- R2: For insn[15:11] in 0..2, the output is 0xE1B00000 with insn[12:11] at [6:5], insn[10:6] at [11:7], insn[5:3] at [3:0] and insn[2:0] at [15:12].
- R3: For insn[15:11]=3, the base is chosen by insn[10:9] from (0xE0900000, 0xE0500000, 0xE2900000, 0xE2500000). It is ORed with insn[8:6] at [3:0], insn[5:3] at [19:16] and insn[2:0] at [15:12]. For insn[15:11] in 4..7, the base is chosen by insn[12:11] from (0xE3B00000, 0xE3500000, 0xE2900000, 0xE2500000). It is ORed with insn[7:0] at [7:0] and with insn[10:8] at both [19:16] and [15:12].
- R4: For insn[15:10]=010000, op=insn[9:6] selects a base from (E0100000, E0300000, E1B00010, E1B00030, E1B00050, E0B00000, E0D00000, E1B00070, E1100000, E2700000, E1500000, E1700000, E1900000, E0100090, E1D00000, E1F00000). With d=insn[2:0] and s=insn[5:3], the fields are placed as follows:
  - ops 2, 3, 4 and 7: d at [15:12] and [3:0], s at [11:8];
  - op 9: d at [15:12], s at [19:16];
  - op 13: d at [19:16] and [11:8], s at [3:0];
  - all other ops: d at [19:16] and [15:12], s at [3:0].
- R5: For insn[15:10]=010001, let D={insn[7],insn[2:0]} and S={insn[6],insn[5:3]}. Ops insn[9:6] 1..3, 5..7 and 9..11 give 0xE0800000, 0xE1500000 and 0xE1A00000, each ORed with D at [19:16] and [15:12] and S at [3:0]. Ops 12..13 give 0xE12FFF10 with insn[6:3] at [3:0]. Ops 0, 4 and 8 are undefined.
- R6: Ops 14..15 of R5 give 0xE12FFF30 with insn[6:3] at [3:0] only when `arch_v5` is 1; otherwise they are undefined.
- R7: Loads and stores are expanded as follows, with insn[2:0] at [15:12] and insn[5:3] at [19:16] throughout:
  - Register offset (insn[15:12]=0101, insn[8:6] at [3:0]): when insn[9]=0, insn[11:10] picks from (E7800000, E7C00000, E7900000, E7D00000); when insn[9]=1 it picks from (E18000B0, E19000D0, E19000B0, E19000F0).
  - Immediate (insn[15:11] 12..15): the base is chosen by insn[12:11] from (E5800000, E5900000, E5C00000, E5D00000). The offset is insn[10:6]×4 when insn[12]=0 and insn[10:6] unscaled when insn[12]=1.
  - Halfword (insn[15:11] 16/17): the base is 0xE1C000B0, or 0xE1D000B0 when insn[11] is set. The offset insn[10:6]×2 has its bits [3:0] at [3:0] and its bits [5:4] at [9:8].
- R8: Relative forms all place insn[10:8] at [15:12]:
  - insn[15:11]=9 gives 0xE59F0000 with insn[7:0]×4 at [9:0].
  - insn[15:11]=18/19 gives 0xE58D0000 (0xE59D0000 if insn[11] is set) with insn[7:0]×4.
  - insn[15:11]=20/21 gives 0xE28F0F00 (0xE28D0F00 if insn[11] is set) with insn[7:0] unscaled.
  - insn[15:8]=0xB0 gives 0xE28DDF00 (0xE24DDF00 if insn[7] is set) with insn[6:0].
- R9: Save and restore of a register list, and multiple transfers:
  - insn[15:8]=0xB4/0xB5 give 0xE92D0000 | insn[7:0], plus bit 14 for 0xB5.
  - insn[15:8]=0xBC/0xBD give 0xE8BD0000 | insn[7:0], plus bit 15 for 0xBD.
  - insn[15:11]=24/25 give 0xE8A00000 (0xE8B00000 if insn[11] is set) with insn[10:8] at [19:16] and insn[7:0] at [7:0].
- R10: insn[15:8]=0xBE gives 0xE1200070 with insn[7:4] at [11:8] and insn[3:0] at [3:0] only when `arch_v5` is 1; otherwise it is undefined.
- R11: insn[15:8]=0xDF gives 0xEF000000 | insn[7:0].
- R12: Every other pattern is undefined. This includes all of insn[15:11] 26..31 except R11's pattern, and the unused insn[11:8] values under 0xB. An undefined result sets `out_undef` and forces `out_word` to 0. A defined result clears `out_undef` and always has 0xE in bits [31:28].
- R13: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_word` and `out_undef` change only then. After reset all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| fetch_word | input | 32 | Two packed halfwords |
| hi_half_sel | input | 1 | 1 selects the upper halfword |
| arch_v5 | input | 1 | Enables the later-level encodings |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_word | output | 32 | Expanded instruction, or 0 when undefined |
| out_undef | output | 1 | Instruction is undefined here |

## Verification
Every one of the 65536 halfwords is expanded, with the level flag and the half select varied across the sweep and unrelated bits in the other half. Several mistakes would show up directly in the sweep:
- Scaling the byte offset like the word offset would give a byte access four times too far away.
- Misplacing the halfword offset nibbles would corrupt bits [9:8].
- Dropping the high-register bits would alias r8..r15 onto r0..r7.

Two encodings depend on the level flag, and both sides of that gating are compared against zeroed undefined results. An ungated design would emit the exchange-and-link or breakpoint word on the earlier level. The cycle after each strobe is also checked, to catch a valid flag that lingers or outputs that follow the input while idle.

// File: rtl/cinsn_expand.sv
module cinsn_expand (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] fetch_word,
  input  logic        hi_half_sel,
  input  logic        arch_v5,
  output logic        out_valid,
  output logic [31:0] out_word,
  output logic        out_undef
);

  logic [15:0] ins;
  logic [2:0]  rd, rs, rn, rh;
  logic [3:0]  hd, hs;
  logic [31:0] alu_base;
  logic [1:0]  alu_cls;
  logic [31:0] dec_word;
  logic        dec_undef;

  assign ins = hi_half_sel ? fetch_word[31:16] : fetch_word[15:0];
  assign rd  = ins[2:0];
  assign rs  = ins[5:3];
  assign rn  = ins[8:6];
  assign rh  = ins[10:8];
  assign hd  = {ins[7], ins[2:0]};
  assign hs  = {ins[6], ins[5:3]};

  // class: 0 plain, 1 shift by register, 2 negate, 3 multiply
  always_comb begin
    alu_cls = 2'd0;
    case (ins[9:6])
      4'd0:  alu_base = 32'hE0100000;
      4'd1:  alu_base = 32'hE0300000;
      4'd2:  begin alu_base = 32'hE1B00010; alu_cls = 2'd1; end
      4'd3:  begin alu_base = 32'hE1B00030; alu_cls = 2'd1; end
      4'd4:  begin alu_base = 32'hE1B00050; alu_cls = 2'd1; end
      4'd5:  alu_base = 32'hE0B00000;
      4'd6:  alu_base = 32'hE0D00000;
      4'd7:  begin alu_base = 32'hE1B00070; alu_cls = 2'd1; end
      4'd8:  alu_base = 32'hE1100000;
      4'd9:  begin alu_base = 32'hE2700000; alu_cls = 2'd2; end
      4'd10: alu_base = 32'hE1500000;
      4'd11: alu_base = 32'hE1700000;
      4'd12: alu_base = 32'hE1900000;
      4'd13: begin alu_base = 32'hE0100090; alu_cls = 2'd3; end
      4'd14: alu_base = 32'hE1D00000;
      default: alu_base = 32'hE1F00000;
    endcase
  end

  always_comb begin
    dec_word  = 32'd0;
    dec_undef = 1'b0;
    case (ins[15:11])
      5'd0, 5'd1, 5'd2:
        dec_word = 32'hE1B00000 | (32'(ins[12:11]) << 5) | (32'(ins[10:6]) << 7)
                 | 32'(rs) | (32'(rd) << 12);
      5'd3: begin
        case (ins[10:9])
          2'd0: dec_word = 32'hE0900000;
          2'd1: dec_word = 32'hE0500000;
          2'd2: dec_word = 32'hE2900000;
          default: dec_word = 32'hE2500000;
        endcase
        dec_word = dec_word | 32'(rn) | (32'(rs) << 16) | (32'(rd) << 12);
      end
      5'd4, 5'd5, 5'd6, 5'd7: begin
        case (ins[12:11])
          2'd0: dec_word = 32'hE3B00000;
          2'd1: dec_word = 32'hE3500000;
          2'd2: dec_word = 32'hE2900000;
          default: dec_word = 32'hE2500000;
        endcase
        dec_word = dec_word | 32'(ins[7:0]) | (32'(rh) << 16) | (32'(rh) << 12);
      end
      5'd8: begin
        if (!ins[10]) begin
          case (alu_cls)
            2'd0: dec_word = alu_base | (32'(rd) << 16) | (32'(rd) << 12) | 32'(rs);
            2'd1: dec_word = alu_base | (32'(rd) << 12) | 32'(rd) | (32'(rs) << 8);
            2'd2: dec_word = alu_base | (32'(rd) << 12) | (32'(rs) << 16);
            default: dec_word = alu_base | (32'(rd) << 16) | (32'(rd) << 8) | 32'(rs);
          endcase
        end else begin
          case (ins[9:6])
            4'd1, 4'd2, 4'd3:
              dec_word = 32'hE0800000 | (32'(hd) << 16) | (32'(hd) << 12) | 32'(hs);
            4'd5, 4'd6, 4'd7:
              dec_word = 32'hE1500000 | (32'(hd) << 16) | (32'(hd) << 12) | 32'(hs);
            4'd9, 4'd10, 4'd11:
              dec_word = 32'hE1A00000 | (32'(hd) << 16) | (32'(hd) << 12) | 32'(hs);
            4'd12, 4'd13:
              dec_word = 32'hE12FFF10 | 32'(ins[6:3]);
            4'd14, 4'd15: begin
              if (arch_v5) dec_word = 32'hE12FFF30 | 32'(ins[6:3]);
              else         dec_undef = 1'b1;
            end
            default: dec_undef = 1'b1;
          endcase
        end
      end
      5'd9:
        dec_word = 32'hE59F0000 | (32'(rh) << 12) | (32'(ins[7:0]) << 2);
      5'd10, 5'd11: begin
        case ({ins[9], ins[11:10]})
          3'b000: dec_word = 32'hE7800000;
          3'b001: dec_word = 32'hE7C00000;
          3'b010: dec_word = 32'hE7900000;
          3'b011: dec_word = 32'hE7D00000;
          3'b100: dec_word = 32'hE18000B0;
          3'b101: dec_word = 32'hE19000D0;
          3'b110: dec_word = 32'hE19000B0;
          default: dec_word = 32'hE19000F0;
        endcase
        dec_word = dec_word | (32'(rd) << 12) | (32'(rs) << 16) | 32'(rn);
      end
      5'd12, 5'd13, 5'd14, 5'd15: begin
        case (ins[12:11])
          2'd0: dec_word = 32'hE5800000;
          2'd1: dec_word = 32'hE5900000;
          2'd2: dec_word = 32'hE5C00000;
          default: dec_word = 32'hE5D00000;
        endcase
        dec_word = dec_word | (32'(rd) << 12) | (32'(rs) << 16)
                 | (ins[12] ? 32'(ins[10:6]) : (32'(ins[10:6]) << 2));
      end
      5'd16, 5'd17:
        dec_word = (ins[11] ? 32'hE1D000B0 : 32'hE1C000B0)
                 | (32'(rd) << 12) | (32'(rs) << 16)
                 | (32'(ins[8:6]) << 1) | (32'(ins[10:9]) << 8);
      5'd18, 5'd19:
        dec_word = (ins[11] ? 32'hE59D0000 : 32'hE58D0000)
                 | (32'(rh) << 12) | (32'(ins[7:0]) << 2);
      5'd20, 5'd21:
        dec_word = (ins[11] ? 32'hE28D0F00 : 32'hE28F0F00)
                 | (32'(rh) << 12) | 32'(ins[7:0]);
      5'd22, 5'd23: begin
        case (ins[11:8])
          4'h0: dec_word = (ins[7] ? 32'hE24DDF00 : 32'hE28DDF00) | 32'(ins[6:0]);
          4'h4: dec_word = 32'hE92D0000 | 32'(ins[7:0]);
          4'h5: dec_word = 32'hE92D4000 | 32'(ins[7:0]);
          4'hC: dec_word = 32'hE8BD0000 | 32'(ins[7:0]);
          4'hD: dec_word = 32'hE8BD8000 | 32'(ins[7:0]);
          4'hE: begin
            if (arch_v5) dec_word = 32'hE1200070 | (32'(ins[7:4]) << 8) | 32'(ins[3:0]);
            else         dec_undef = 1'b1;
          end
          default: dec_undef = 1'b1;
        endcase
      end
      5'd24, 5'd25:
        dec_word = (ins[11] ? 32'hE8B00000 : 32'hE8A00000)
                 | (32'(rh) << 16) | 32'(ins[7:0]);
      5'd27: begin
        if (ins[10:8] == 3'b111) dec_word = 32'hEF000000 | 32'(ins[7:0]);
        else                     dec_undef = 1'b1;
      end
      default: dec_undef = 1'b1;
    endcase
    if (dec_undef) dec_word = 32'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= 32'd0;
      out_undef <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= dec_word;
        out_undef <= dec_undef;
      end
    end
  end

  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R13
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R13
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_word) && $stable(out_undef)); // R13
  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) out_undef |-> out_word == 32'd0); // R12
  AST_COND_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n) out_valid && !out_undef |-> out_word[31:28] == 4'hE); // R12
  AST_BLX_GATED: assert property (@(posedge clk) disable iff (!rst_n) in_valid && !arch_v5 && ins[15:7] == 9'b010001111 |=> out_undef); // R6
  AST_BKPT_GATED: assert property (@(posedge clk) disable iff (!rst_n) in_valid && !arch_v5 && ins[15:8] == 8'hBE |=> out_undef); // R10
  AST_SWI_FIELD: assert property (@(posedge clk) disable iff (!rst_n) in_valid && ins[15:8] == 8'hDF |=> out_word == {24'hEF0000, $past(ins[7:0])}); // R11

endmodule

// File: tb/cinsn_expand_bench.sv
module cinsn_expand_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] fetch_word = 32'd0;
  logic        hi_half_sel = 1'b0;
  logic        arch_v5 = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_undef;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cinsn_expand u_cinsn_expand (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fetch_word(fetch_word),
    .hi_half_sel(hi_half_sel), .arch_v5(arch_v5),
    .out_valid(out_valid), .out_word(out_word), .out_undef(out_undef)
  );

  task automatic chk(input string req, input logic [15:0] h, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s insn=%h actual=%h expected=%h", req, h, act, exp);
    end
  endtask

  function automatic void model(input logic [15:0] h, input logic v5,
                                output logic [31:0] w, output logic u, output string tag);
    logic [31:0] x, top, d, s, n, r, op, sub, base, off, hd, hs;
    x = {16'd0, h};
    top = x >> 11;
    d = x & 32'd7; s = (x >> 3) & 32'd7; n = (x >> 6) & 32'd7; r = (x >> 8) & 32'd7;
    sub = (x >> 8) & 32'd15;
    w = 32'd0; u = 1'b0; tag = "R12";
    if (top <= 32'd2) begin
      tag = "R2";
      w = 32'hE1B00000 | (top << 5) | (((x >> 6) & 32'd31) << 7) | s | (d << 12);
    end else if (top == 32'd3) begin
      tag = "R3";
      op = (x >> 9) & 32'd3;
      base = (op == 0) ? 32'hE0900000 : (op == 1) ? 32'hE0500000 : (op == 2) ? 32'hE2900000 : 32'hE2500000;
      w = base | n | (s << 16) | (d << 12);
    end else if (top <= 32'd7) begin
      tag = "R3";
      op = top - 32'd4;
      base = (op == 0) ? 32'hE3B00000 : (op == 1) ? 32'hE3500000 : (op == 2) ? 32'hE2900000 : 32'hE2500000;
      w = base | (x & 32'd255) | (r << 16) | (r << 12);
    end else if (top == 32'd8 && x[10] == 1'b0) begin
      tag = "R4";
      op = (x >> 6) & 32'd15;
      case (op)
        0: base = 32'hE0100000;  1: base = 32'hE0300000;  2: base = 32'hE1B00010;  3: base = 32'hE1B00030;
        4: base = 32'hE1B00050;  5: base = 32'hE0B00000;  6: base = 32'hE0D00000;  7: base = 32'hE1B00070;
        8: base = 32'hE1100000;  9: base = 32'hE2700000;  10: base = 32'hE1500000; 11: base = 32'hE1700000;
        12: base = 32'hE1900000; 13: base = 32'hE0100090; 14: base = 32'hE1D00000; default: base = 32'hE1F00000;
      endcase
      if (op == 2 || op == 3 || op == 4 || op == 7) w = base | (d << 12) | d | (s << 8);
      else if (op == 9) w = base | (d << 12) | (s << 16);
      else if (op == 13) w = base | (d << 16) | (d << 8) | s;
      else w = base | (d << 16) | (d << 12) | s;
    end else if (top == 32'd8) begin
      op = (x >> 6) & 32'd15;
      hd = d + (x[7] ? 32'd8 : 32'd0);
      hs = s + (x[6] ? 32'd8 : 32'd0);
      tag = "R5";
      if (op >= 1 && op <= 3) w = 32'hE0800000 | (hd << 16) | (hd << 12) | hs;
      else if (op >= 5 && op <= 7) w = 32'hE1500000 | (hd << 16) | (hd << 12) | hs;
      else if (op >= 9 && op <= 11) w = 32'hE1A00000 | (hd << 16) | (hd << 12) | hs;
      else if (op == 12 || op == 13) w = 32'hE12FFF10 | ((x >> 3) & 32'd15);
      else if (op >= 14) begin
        tag = "R6";
        if (v5) w = 32'hE12FFF30 | ((x >> 3) & 32'd15);
        else u = 1'b1;
      end else u = 1'b1;
    end else if (top == 32'd9) begin
      tag = "R8";
      w = 32'hE59F0000 | (r << 12) | ((x & 32'd255) * 32'd4);
    end else if (top == 32'd10 || top == 32'd11) begin
      tag = "R7";
      op = (x >> 10) & 32'd3;
      if (x[9] == 1'b0)
        base = (op == 0) ? 32'hE7800000 : (op == 1) ? 32'hE7C00000 : (op == 2) ? 32'hE7900000 : 32'hE7D00000;
      else
        base = (op == 0) ? 32'hE18000B0 : (op == 1) ? 32'hE19000D0 : (op == 2) ? 32'hE19000B0 : 32'hE19000F0;
      w = base | (d << 12) | (s << 16) | n;
    end else if (top <= 32'd15) begin
      tag = "R7";
      op = top - 32'd12;
      base = (op == 0) ? 32'hE5800000 : (op == 1) ? 32'hE5900000 : (op == 2) ? 32'hE5C00000 : 32'hE5D00000;
      off = (x >> 6) & 32'd31;
      if (op < 2) off = off * 32'd4;
      w = base | (d << 12) | (s << 16) | off;
    end else if (top <= 32'd17) begin
      tag = "R7";
      off = ((x >> 6) & 32'd31) * 32'd2;
      w = (x[11] ? 32'hE1D000B0 : 32'hE1C000B0) | (d << 12) | (s << 16) | (off & 32'd15) | ((off >> 4) << 8);
    end else if (top <= 32'd19) begin
      tag = "R8";
      w = (x[11] ? 32'hE59D0000 : 32'hE58D0000) | (r << 12) | ((x & 32'd255) * 32'd4);
    end else if (top <= 32'd21) begin
      tag = "R8";
      w = (x[11] ? 32'hE28D0F00 : 32'hE28F0F00) | (r << 12) | (x & 32'd255);
    end else if (top <= 32'd23) begin
      if (sub == 0) begin tag = "R8"; w = (x[7] ? 32'hE24DDF00 : 32'hE28DDF00) | (x & 32'd127); end
      else if (sub == 4 || sub == 5) begin tag = "R9"; w = 32'hE92D0000 | (x & 32'd255) | ((sub == 5) ? 32'h4000 : 32'd0); end
      else if (sub == 12 || sub == 13) begin tag = "R9"; w = 32'hE8BD0000 | (x & 32'd255) | ((sub == 13) ? 32'h8000 : 32'd0); end
      else if (sub == 14) begin
        tag = "R10";
        if (v5) w = 32'hE1200070 | (((x >> 4) & 32'd15) << 8) | (x & 32'd15);
        else u = 1'b1;
      end else u = 1'b1;
    end else if (top <= 32'd25) begin
      tag = "R9";
      w = (x[11] ? 32'hE8B00000 : 32'hE8A00000) | (r << 16) | (x & 32'd255);
    end else if ((x >> 8) == 32'hDF) begin
      tag = "R11";
      w = 32'hEF000000 | (x & 32'd255);
    end else u = 1'b1;
  endfunction

  task automatic apply(input logic [15:0] h, input logic [15:0] oth, input logic hi, input logic v5, input string note);
    logic [31:0] ew;
    logic        eu;
    string       tg;
    logic [31:0] held;
    model(h, v5, ew, eu, tg);
    tg = {tg, note};
    fetch_word  = hi ? {h, oth} : {oth, h};
    hi_half_sel = hi;
    arch_v5     = v5;
    in_valid    = 1'b1;
    @(negedge clk);
    in_valid   = 1'b0;
    fetch_word = ~fetch_word;
    arch_v5    = ~v5;
    chk(tg, h, out_word, ew);
    chk(tg, h, {31'd0, out_undef}, {31'd0, eu});
    chk("R13 valid pulse", h, {31'd0, out_valid}, 32'd1);
    held = out_word;
    @(negedge clk);
    chk("R13 valid drops", h, {31'd0, out_valid}, 32'd0);
    chk("R13 word held", h, out_word, held);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL R13 watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset valid", 16'h0, {31'd0, out_valid}, 32'd0);
    chk("R13 reset word", 16'h0, out_word, 32'd0);
    chk("R13 reset undef", 16'h0, {31'd0, out_undef}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: same instruction from either half, different neighbour
    apply(16'h1C48, 16'hDF12, 1'b0, 1'b0, " R1 low");
    apply(16'h1C48, 16'hBE34, 1'b1, 1'b0, " R1 high");
    apply(16'hDF7E, 16'h4770, 1'b1, 1'b1, " R1 high");
    apply(16'hDF7E, 16'h0000, 1'b0, 1'b1, " R1 low");
    // gating pairs
    apply(16'h47F8, 16'h0000, 1'b0, 1'b1, " v5");
    apply(16'h47F8, 16'h0000, 1'b0, 1'b0, " pre-v5");
    apply(16'hBEA5, 16'h0000, 1'b1, 1'b1, " v5");
    apply(16'hBEA5, 16'h0000, 1'b1, 1'b0, " pre-v5");

    for (int i = 0; i < 65536; i++) begin
      logic [15:0] h;
      logic [15:0] oth;
      h   = 16'(i);
      oth = h ^ 16'hA5C3;
      apply(h, oth, h[1] ^ h[9], h[0] ^ h[12] ^ h[5], "");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule